// File: doc/BRIEF.md
# I2C Command and Byte Engine

This block is the bus half of a register-driven I2C master. Software drives every bus primitive on its own: it issues a start, a repeated start or a stop through a command field in the control register, and it sends one byte by writing the data register. Each action runs to completion on the open-drain SCL and SDA lines. When it finishes, the block raises a session-done status bit. For a byte, it also captures the acknowledge from the slave and keeps it readable in the control register.

The host side is a simple synchronous register port with five registers: control (address 0), data (1), interrupt enable (2), interrupt status (3) and half-period timing (4). Read data is combinational from the address. A busy flag in the status register stays high while an action runs. Writes that would start or change an action are dropped while it is high. SCL timing comes from a programmable half-period counter. Every line phase lasts the timing value plus one clock cycle. Clock stretching, arbitration and high-speed signalling are not handled.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset, SCL and SDA are released (both enables 0), busy is low, control, data, enable and status read 0, timing reads HALF_RST, and the interrupt output is low.
- R2: Status bit 7 (busy) reads 1 from the clock edge that accepts an action until the edge that ends its last line phase. Writes to control, data or timing made while busy is 1 are ignored.
- R3: Control bit 0 is enable, bits 2:1 are the command (0 none, 1 start, 2 stop, 3 treated as none), and bit 3 selects repeated start (1) or plain start (0). A command runs only when the written enable bit is 1. A data write sends the byte only when the stored enable bit is 1.
- R4: A plain start pulls SDA low, then pulls SCL low, leaving both low. A repeated start releases SDA, releases SCL, pulls SDA low and then pulls SCL low.
- R5: A stop pulls SDA low with SCL low, releases SCL, and then releases SDA, leaving the bus idle with both lines released.
- R6: A byte goes out MSB first. Each bit holds SCL low and then releases it for one phase each. In the ninth slot SDA is released and sampled at the end of the SCL-high phase, and SCL is pulled low again when the byte ends.
- R7: When a byte ends, control bit 3 reads 1 if SDA was high in the acknowledge slot (NAK) and 0 if it was low. A NAK also sets status bit 0, and every finished byte sets status bit 1.
- R8: The end of every start, repeated start, stop or byte sets status bit 3 (session done).
- R9: Writing 1 to a status bit clears it. A set in the same cycle wins over the clear. Status bits 2, 4, 5 and 6 are never set and read 0.
- R10: Interrupt-enable bits 0, 1, 3 and 4 are writable and the others read 0. The interrupt output is the OR over those bit positions of enable AND status. Busy never drives it.
- R11: Every line phase lasts T+1 clock cycles, where T is the timing register value, so a start lasts 2(T+1) cycles and a byte 18(T+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The bench builds the engine with DIV_W = 4 and HALF_RST = 3. This makes the full timing range reachable: the zero value gives one-cycle phases and the maximum of 15 gives 16-cycle phases. Short bytes keep the run brief. With these values the bench can measure start and byte lengths at both ends of the counter. It can also run a stop whose completion edge coincides with a write-one-to-clear of session done, and it can issue writes during the short busy windows to show that they are dropped.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_IEN  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_TIME = 3'd4;

    localparam logic [1:0] CMD_START = 2'd1;
    localparam logic [1:0] CMD_STOP  = 2'd2;

    localparam int ST_NAK  = 0;
    localparam int ST_TXE  = 1;
    localparam int ST_DONE = 3;
    localparam int ST_W    = 5;
    localparam logic [7:0] IEN_MASK = 8'h1B;

    typedef enum logic [1:0] {
        OP_START,
        OP_RESTART,
        OP_STOP,
        OP_BYTE
    } op_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_S_A, PH_S_B,
        PH_R_A, PH_R_B, PH_R_C, PH_R_D,
        PH_P_A, PH_P_B, PH_P_C,
        PH_B_LO, PH_B_HI
    } phase_e;
endpackage

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d  = t_q;
        tick = run && (t_q.cnt == '0);
        if (load) begin
            t_d.cnt = half;
        end else if (run) begin
            t_d.cnt = tick ? half : t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R11: the running count never exceeds the programmed half period
    a_r11_count_within_half: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (t_q.cnt <= half));
endmodule

// File: rtl/i2c_bus_seq.sv
module i2c_bus_seq
    import i2c_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  op_e        op,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       sda_in,
    output logic       busy,
    output logic       done,
    output op_e        done_op,
    output logic       done_nak,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam logic [3:0] ACK_SLOT = 4'd8;

    typedef struct packed {
        phase_e     ph;
        logic [3:0] bitn;
        logic [7:0] sh;
        logic       scl;
        logic       sda;
        op_e        op;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (go) begin
                    s_d.op = op;
                    unique case (op)
                        OP_START:   begin s_d.ph = PH_S_A; s_d.scl = 1'b0; s_d.sda = 1'b1; end
                        OP_RESTART: begin s_d.ph = PH_R_A; s_d.scl = 1'b1; s_d.sda = 1'b0; end
                        OP_STOP:    begin s_d.ph = PH_P_A; s_d.scl = 1'b1; s_d.sda = 1'b1; end
                        OP_BYTE: begin
                            s_d.ph   = PH_B_LO;
                            s_d.scl  = 1'b1;
                            s_d.sda  = ~tx_byte[7];
                            s_d.sh   = tx_byte;
                            s_d.bitn = '0;
                        end
                    endcase
                end
            end
            PH_S_A: if (tick) begin s_d.ph = PH_S_B; s_d.scl = 1'b1; end
            PH_S_B: if (tick) begin s_d.ph = PH_IDLE; done = 1'b1; end
            PH_R_A: if (tick) begin s_d.ph = PH_R_B; s_d.scl = 1'b0; end
            PH_R_B: if (tick) begin s_d.ph = PH_R_C; s_d.sda = 1'b1; end
            PH_R_C: if (tick) begin s_d.ph = PH_R_D; s_d.scl = 1'b1; end
            PH_R_D: if (tick) begin s_d.ph = PH_IDLE; done = 1'b1; end
            PH_P_A: if (tick) begin s_d.ph = PH_P_B; s_d.scl = 1'b0; end
            PH_P_B: if (tick) begin s_d.ph = PH_P_C; s_d.sda = 1'b0; end
            PH_P_C: if (tick) begin s_d.ph = PH_IDLE; done = 1'b1; end
            PH_B_LO: if (tick) begin s_d.ph = PH_B_HI; s_d.scl = 1'b0; end
            PH_B_HI: begin
                if (tick) begin
                    s_d.scl = 1'b1;
                    if (s_q.bitn == ACK_SLOT) begin
                        s_d.ph  = PH_IDLE;
                        s_d.sda = 1'b0;
                        done    = 1'b1;
                    end else begin
                        s_d.ph   = PH_B_LO;
                        s_d.bitn = s_q.bitn + 1'b1;
                        s_d.sh   = {s_q.sh[6:0], 1'b0};
                        s_d.sda  = (s_q.bitn == ACK_SLOT - 1'b1) ? 1'b0 : ~s_q.sh[6];
                    end
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_IDLE;
            s_q.op <= OP_START;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.ph != PH_IDLE);
    assign done_op  = s_q.op;
    assign done_nak = sda_in;
    assign scl_oe   = s_q.scl;
    assign sda_oe   = s_q.sda;

    // R3: an accepted command makes the engine busy on the next cycle
    a_r3_go_starts_action: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);

    // R2: busy drops right after the final phase ends
    a_r2_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R4: with SCL released throughout, SDA moves only in start, restart or stop
    a_r4_sda_moves_only_framing: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> (s_q.op != OP_BYTE));

    // R5: a finished stop leaves both lines released
    a_r5_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.op == OP_STOP) |=> (!scl_oe && !sda_oe));
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
    import i2c_eng_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int HALF_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    input  logic              done,
    input  op_e               done_op,
    input  logic              done_nak,
    output logic [7:0]        rdata,
    output logic              irq,
    output logic              go,
    output op_e               op,
    output logic [7:0]        tx_byte,
    output logic [DIV_W-1:0]  half
);
    typedef struct packed {
        logic             en;
        logic [1:0]       cmd;
        logic             b3;
        logic [7:0]       data;
        logic [7:0]       ien;
        logic [ST_W-1:0]  stat;
        logic [DIV_W-1:0] half;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        go  = 1'b0;
        op  = OP_START;
        if (wr) begin
            unique case (addr)
                ADR_CTRL: begin
                    if (!busy) begin
                        r_d.en  = wdata[0];
                        r_d.cmd = wdata[2:1];
                        r_d.b3  = wdata[3];
                        if (wdata[0] && wdata[2:1] == CMD_START) begin
                            go = 1'b1;
                            op = wdata[3] ? OP_RESTART : OP_START;
                        end else if (wdata[0] && wdata[2:1] == CMD_STOP) begin
                            go = 1'b1;
                            op = OP_STOP;
                        end
                    end
                end
                ADR_DATA: begin
                    if (!busy) begin
                        r_d.data = wdata;
                        if (r_q.en) begin
                            go = 1'b1;
                            op = OP_BYTE;
                        end
                    end
                end
                ADR_IEN:  r_d.ien  = wdata & IEN_MASK;
                ADR_STAT: r_d.stat = r_q.stat & ~wdata[ST_W-1:0];
                ADR_TIME: if (!busy) r_d.half = wdata[DIV_W-1:0];
                default: ;
            endcase
        end
        if (done) begin
            r_d.stat[ST_DONE] = 1'b1;
            if (done_op == OP_BYTE) begin
                r_d.b3           = done_nak;
                r_d.stat[ST_TXE] = 1'b1;
                if (done_nak) r_d.stat[ST_NAK] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.half <= DIV_W'(HALF_RST);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (addr)
            ADR_CTRL: rdata = {4'b0, r_q.b3, r_q.cmd, r_q.en};
            ADR_DATA: rdata = r_q.data;
            ADR_IEN:  rdata = r_q.ien;
            ADR_STAT: rdata = {busy, 2'b00, r_q.stat};
            ADR_TIME: rdata = 8'(r_q.half);
            default:  rdata = 8'h00;
        endcase
    end

    assign irq     = |(r_q.ien[ST_W-1:0] & r_q.stat);
    assign tx_byte = wdata;
    assign half    = r_q.half;

    // R8: the end of any action leaves session done set
    a_r8_done_sets_session: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> r_q.stat[ST_DONE]);

    // R7: a byte that ends with SDA high leaves the NAK flag set
    a_r7_nak_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_op == OP_BYTE && done_nak) |=> (r_q.stat[ST_NAK] && r_q.b3));

    // R2: timing value cannot change while an action runs
    a_r2_timing_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(r_q.half));
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
    import i2c_eng_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int HALF_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_in
);
    logic             go, busy, done, done_nak, tick;
    op_e              op, done_op;
    logic [7:0]       tx_byte;
    logic [DIV_W-1:0] half;

    i2c_host_regs #(.DIV_W(DIV_W), .HALF_RST(HALF_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .busy     (busy),
        .done     (done),
        .done_op  (done_op),
        .done_nak (done_nak),
        .rdata    (reg_rdata),
        .irq      (irq),
        .go       (go),
        .op       (op),
        .tx_byte  (tx_byte),
        .half     (half)
    );

    i2c_half_timer #(.DIV_W(DIV_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go),
        .run   (busy),
        .half  (half),
        .tick  (tick)
    );

    i2c_bus_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .op       (op),
        .tx_byte  (tx_byte),
        .tick     (tick),
        .sda_in   (sda_in),
        .busy     (busy),
        .done     (done),
        .done_op  (done_op),
        .done_nak (done_nak),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe)
    );
endmodule

// File: tb/sim_i2c_cmd_engine.sv
module sim_i2c_cmd_engine;
    localparam int DIV_W    = 4;
    localparam int HALF_RST = 3;
    localparam logic [6:0] SLV_ADDR = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd3;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic irq, scl_oe, sda_oe;
    logic slv_pull = 1'b0;
    wire  scl_line = !scl_oe;
    wire  sda_line = !(sda_oe | slv_pull);

    always #5 clk = ~clk;

    i2c_cmd_engine #(.DIV_W(DIV_W), .HALF_RST(HALF_RST)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
    );

    int vec = 0;
    int miss = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- slave model ----------------
    int slv_cnt = 0;
    logic [7:0] slv_sh = 8'h00;
    bit slv_first = 1'b0;
    bit force_nak = 1'b0;

    always @(negedge sda_line) begin
        #1;
        if (rst_n === 1'b1 && scl_line === 1'b1 && sda_line === 1'b0) begin
            slv_cnt = 0; slv_first = 1'b1; slv_pull = 1'b0;
        end
    end
    always @(posedge scl_line) begin
        if (rst_n === 1'b1 && slv_cnt < 8) begin
            slv_sh = {slv_sh[6:0], sda_line};
            slv_cnt++;
        end
    end
    always @(negedge scl_line) begin
        if (rst_n === 1'b1) begin
            if (slv_cnt == 8) begin
                slv_pull  = slv_first ? (slv_sh[7:1] == SLV_ADDR && !force_nak) : !force_nak;
                slv_first = 1'b0;
                slv_cnt   = 9;
            end else if (slv_cnt == 9) begin
                slv_pull = 1'b0;
                slv_cnt  = 0;
            end
        end
    end

    // ---------------- reference model ----------------
    int q[$];
    int m_cnt = 0, m_kind = 0;
    bit m_busy = 0, m_scl = 0, m_sda = 0, m_en = 0, m_b3 = 0, m_nak = 0, addr_phase = 0;
    logic [1:0] m_cmd = 2'd0;
    logic [7:0] m_data = 0, m_ien = 0;
    logic [4:0] m_stat = 0;
    logic [3:0] m_half = HALF_RST;

    task automatic launch(int kind, logic [7:0] b);
        q.delete();
        m_kind = kind;
        case (kind)
            0: begin q.push_back(1); q.push_back(3); end
            1: begin q.push_back(2); q.push_back(0); q.push_back(1); q.push_back(3); end
            2: begin q.push_back(3); q.push_back(1); q.push_back(0); end
            default: begin
                for (int i = 7; i >= 0; i--) begin
                    q.push_back(2 + (b[i] ? 0 : 1));
                    q.push_back(b[i] ? 0 : 1);
                end
                q.push_back(2); q.push_back(0);
            end
        endcase
        m_scl = q[0][1]; m_sda = q[0][0];
        m_cnt = m_half; m_busy = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_busy = 0; m_scl = 0; m_sda = 0; m_en = 0; m_b3 = 0;
            m_cmd = 0; m_data = 0; m_ien = 0; m_stat = 0; m_half = HALF_RST; addr_phase = 0;
        end else begin
            bit was_busy;
            was_busy = m_busy;
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: if (!was_busy) begin
                        m_en = reg_wdata[0]; m_cmd = reg_wdata[2:1]; m_b3 = reg_wdata[3];
                        if (reg_wdata[0] && reg_wdata[2:1] == 2'd1) begin
                            launch(reg_wdata[3] ? 1 : 0, 8'h00); addr_phase = 1;
                        end else if (reg_wdata[0] && reg_wdata[2:1] == 2'd2) launch(2, 8'h00);
                    end
                    3'd1: if (!was_busy) begin
                        m_data = reg_wdata;
                        if (m_en) begin
                            m_nak = addr_phase ? ((reg_wdata[7:1] != SLV_ADDR) || force_nak) : force_nak;
                            addr_phase = 0;
                            launch(3, reg_wdata);
                        end
                    end
                    3'd2: m_ien = reg_wdata & 8'h1B;
                    3'd3: m_stat = m_stat & ~reg_wdata[4:0];
                    3'd4: if (!was_busy) m_half = reg_wdata[3:0];
                    default: ;
                endcase
            end
            if (was_busy) begin
                if (m_cnt == 0) begin
                    void'(q.pop_front());
                    if (q.size() == 0) begin
                        m_busy = 0; m_stat[3] = 1'b1;
                        if (m_kind == 3) begin
                            m_b3 = m_nak; m_stat[1] = 1'b1;
                            if (m_nak) m_stat[0] = 1'b1;
                            m_scl = 1; m_sda = 0;
                        end
                    end else begin
                        m_scl = q[0][1]; m_sda = q[0][0]; m_cnt = m_half;
                    end
                end else m_cnt--;
            end
        end
    end

    bit cmp_on = 0;
    always @(negedge clk) begin
        #2;
        if (cmp_on) begin
            logic [7:0] er;
            string lt;
            lt = (m_kind == 2) ? "R5 lines" : (m_kind == 3) ? "R6 lines" : "R4 lines";
            case (reg_addr)
                3'd0: er = {4'b0, m_b3, m_cmd, m_en};
                3'd1: er = m_data;
                3'd2: er = m_ien;
                3'd3: er = {m_busy, 2'b00, m_stat};
                3'd4: er = {4'b0, m_half};
                default: er = 8'h00;
            endcase
            chk(lt, {scl_oe, sda_oe}, {m_scl, m_sda});
            chk("R10 irq", irq, |(m_ien[4:0] & m_stat));
            chk((reg_addr == 3'd3) ? "R9 status/R2 busy" : "R3 register readback", reg_rdata, er);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr_now(logic [2:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd3;
    endtask
    task automatic wr_reg(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_now(a, d);
    endtask
    task automatic rd(logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #3 v = reg_rdata;
    endtask
    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask
    task automatic busy_len(output int n);
        n = 0;
        #3;
        while (reg_rdata[7] === 1'b1) begin
            n++;
            @(negedge clk);
            #3;
        end
    endtask

    initial begin
        #(200000 * 10);
        miss++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        logic [1:0] lines;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(3'd3, v); chk("R1 status", v, 8'h00);
        rd(3'd4, v); chk("R1 timing", v, 8'(HALF_RST));
        chk("R1 lines", {scl_oe, sda_oe}, 2'b00);
        chk("R1 irq", irq, 1'b0);

        // start, session done, interrupt, clear
        wr_reg(3'd2, 8'h08);
        wr_reg(3'd0, 8'h03);
        wait_idle();
        rd(3'd3, v); chk("R8 done after start", v, 8'h08);
        chk("R10 irq on done", irq, 1'b1);
        wr_reg(3'd3, 8'h08);
        rd(3'd3, v); chk("R9 clear done", v, 8'h00);

        // address byte acknowledged, measure length
        wr_reg(3'd2, 8'h0B);
        wr_reg(3'd1, {SLV_ADDR, 1'b0});
        busy_len(n); chk("R11 byte length T=3", n, 72);
        wait_idle();
        rd(3'd0, v); chk("R7 ack readback", v[3], 1'b0);
        rd(3'd3, v); chk("R7 ack status", v, 8'h0A);
        wr_reg(3'd3, 8'hFF);

        // data ack then forced NAK
        wr_reg(3'd1, 8'hA5); wait_idle();
        force_nak = 1'b1;
        wr_reg(3'd1, 8'h3C); wait_idle();
        rd(3'd0, v); chk("R7 nak readback", v[3], 1'b1);
        rd(3'd3, v); chk("R7 nak status", v, 8'h0B);
        force_nak = 1'b0;
        wr_reg(3'd3, 8'hFF);

        // writes during busy are dropped
        wr_reg(3'd1, 8'h11);
        wr_reg(3'd4, 8'h00);
        wr_reg(3'd0, 8'h05);
        wait_idle();
        rd(3'd4, v); chk("R2 timing kept", v, 8'h03);
        rd(3'd1, v); chk("R2 data kept", v, 8'h11);
        rd(3'd0, v); chk("R2 ctrl kept", v[2:0], 3'b011);
        wr_reg(3'd3, 8'hFF);

        // repeated start then wrong address
        wr_reg(3'd0, 8'h0B); wait_idle();
        rd(3'd3, v); chk("R8 done after restart", v[3], 1'b1);
        chk("R4 restart leaves both low", {scl_oe, sda_oe}, 2'b11);
        wr_reg(3'd1, 8'h80); wait_idle();
        rd(3'd0, v); chk("R7 address nak", v[3], 1'b1);
        wr_reg(3'd3, 8'hFF);

        // stop with clear landing on the completion edge
        wr_reg(3'd0, 8'h05);
        forever begin
            @(negedge clk);
            if (m_busy && q.size() == 1 && m_cnt == 0) break;
        end
        wr_now(3'd3, 8'h08);
        rd(3'd3, v); chk("R9 set wins over clear", v[3], 1'b1);
        chk("R5 idle after stop", {scl_oe, sda_oe}, 2'b00);

        // commands that must not run
        lines = {scl_oe, sda_oe};
        wr_reg(3'd0, 8'h07);
        rd(3'd3, v); chk("R3 cmd 3 no action", v[7], 1'b0);
        wr_reg(3'd0, 8'h02);
        rd(3'd3, v); chk("R3 start without enable", v[7], 1'b0);
        wr_reg(3'd1, 8'h55);
        rd(3'd3, v); chk("R3 data without enable", v[7], 1'b0);
        chk("R3 lines untouched", {scl_oe, sda_oe}, lines);

        // timing extremes
        wr_reg(3'd4, 8'h00);
        wr_reg(3'd0, 8'h03);
        busy_len(n); chk("R11 start length T=0", n, 2);
        wait_idle();
        wr_reg(3'd4, 8'h0F);
        wr_reg(3'd1, {SLV_ADDR, 1'b1});
        busy_len(n); chk("R11 byte length T=15", n, 288);
        wait_idle();
        rd(3'd0, v); chk("R6 read address acked", v[3], 1'b0);

        // enable mask and reserved status bits
        wr_reg(3'd2, 8'hFF);
        rd(3'd2, v); chk("R10 enable mask", v, 8'h1B);
        wr_reg(3'd3, 8'hFF);
        rd(3'd3, v); chk("R9 status all clear", v, 8'h00);
        chk("R10 irq low", irq, 1'b0);

        wr_reg(3'd4, 8'h01);
        wr_reg(3'd0, 8'h05); wait_idle();
        chk("R5 final stop released", {scl_oe, sda_oe}, 2'b00);

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end
endmodule